// File: doc/BRIEF.md
# Complementary Dead-Band Generator

This block turns a single raw pulse-width-modulated level into the two gate drives of one half-bridge leg. The high-side gate follows the raw level, but only turns on after the level has been high for a programmable number of clock cycles. The low-side gate follows the inverted level, and only turns on after the raw level has been low for a second, independent number of cycles. Both gates turn off as soon as the raw level leaves their active state. The dead time sits in front of each turn-on edge, so the two switches are never driven on together.

The raw level is sampled once on each rising clock edge. Both gates are then derived from one shared counter that measures how long the sampled level has held its present value. The two delay counts are live inputs, 10 bits wide by default. A typical setting is 100 for each, which gives 1 µs of dead time at a 100 MHz clock. A delay of zero turns the matching edge into a plain pass-through of the sampled level.

Top module: `dead_band_gen`

## Requirements
- R1: While rst_n is low, gate_hi and gate_lo are both 0.
- R2: If pwm_in is sampled 1 at rising edge E after having been sampled 0, or after reset release, gate_hi becomes 1 after edge E+rise_dly, provided pwm_in is still sampled 1 at every edge up to and including E+rise_dly.
- R3: gate_hi is 0 in every cycle that follows an edge at which pwm_in was sampled 0.
- R4: If pwm_in is sampled 0 at edge E after having been sampled 1, or after reset release, gate_lo becomes 1 after edge E+fall_dly, provided pwm_in is still sampled 0 at every edge up to and including E+fall_dly.
- R5: gate_lo is 0 in every cycle that follows an edge at which pwm_in was sampled 1.
- R6: A high run of pwm_in lasting at most rise_dly sampled edges produces no gate_hi pulse. A low run lasting at most fall_dly sampled edges produces no gate_lo pulse.
- R7: gate_hi and gate_lo are never 1 in the same cycle.
- R8: A delay value of 0 adds no cycles. With rise_dly = 0, gate_hi equals the sampled pwm_in in the cycle after each edge. With fall_dly = 0, gate_lo equals its inverse.
- R9: Delays up to 1023 are honoured. A level held for longer than 1023 cycles keeps its gate on, because the run counter saturates and does not wrap.
- R10: The first edge after reset release counts as the start of a new level, whatever level pwm_in had during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pwm_in is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Raw modulated level |
| rise_dly | input | CNT_W (10) | Cycles of delay before gate_hi turns on |
| fall_dly | input | CNT_W (10) | Cycles of delay before gate_lo turns on |
| gate_hi | output | 1 | High-side gate drive, active high |
| gate_lo | output | 1 | Low-side gate drive, active high |

## Verification
Each gate is due in the cycle after the rising edge that samples pwm_in. A turn-off is due right then. A turn-on is due a further rise_dly or fall_dly edges later. The bench changes pwm_in and the delay inputs only on the falling clock edge and compares both gates at the next falling edge. At that point exactly one sampling edge has passed, and the gates have settled from the registered level. The expected value comes from a window over the bench's own history of driven samples: a gate is expected on only when the last delay+1 samples since reset all hold its active level. This check runs every cycle, including the no-overlap check and the saturated 1023-cycle case.

// File: rtl/db_pkg.sv
package db_pkg;

    // Default width of the delay counts and of the level run counter.
    localparam int unsigned DB_CNT_W_DEF = 10;

    // Gate indices; the active sampled level of each side follows from its index.
    localparam int unsigned DB_SIDE_HI = 0;
    localparam int unsigned DB_SIDE_LO = 1;
    localparam int unsigned DB_NUM_SIDES = 2;

    // Level on which a side's gate may turn on.
    function automatic logic db_active_level(input int unsigned side);
        return (side == DB_SIDE_HI) ? 1'b1 : 1'b0;
    endfunction

endpackage

// File: rtl/db_level_track.sv
// Samples the raw level and counts how long it has held its present value.
module db_level_track #(
    parameter int unsigned CNT_W = db_pkg::DB_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_in,
    output logic             level_q,
    output logic             armed_q,
    output logic [CNT_W-1:0] run_q
);

    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             level;
        logic             armed;
        logic [CNT_W-1:0] run;
    } trk_t;

    trk_t trk_d;
    trk_t trk_q;

    always_comb begin
        trk_d       = trk_q;
        trk_d.level = level_in;
        trk_d.armed = 1'b1;
        // R10: the first edge after reset starts a fresh run.
        if (!trk_q.armed || (level_in != trk_q.level)) begin
            trk_d.run = '0;
        end else if (trk_q.run != RUN_MAX) begin
            // R9: saturate, never wrap back to zero.
            trk_d.run = trk_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign level_q = trk_q.level;
    assign armed_q = trk_q.armed;
    assign run_q   = trk_q.run;

endmodule

// File: rtl/db_gate_qual.sv
// Turns one gate on once the tracked level has held its active value for dly cycles.
module db_gate_qual #(
    parameter int unsigned CNT_W        = db_pkg::DB_CNT_W_DEF,
    parameter bit          ACTIVE_LEVEL = 1'b1
) (
    input  logic             level_q,
    input  logic             armed_q,
    input  logic [CNT_W-1:0] run_q,
    input  logic [CNT_W-1:0] dly,
    output logic             gate
);

    logic level_ok;
    logic time_ok;

    always_comb begin
        level_ok = (level_q == ACTIVE_LEVEL);
        // R8: a zero delay is met by run 0, the first cycle of the level.
        time_ok  = (run_q >= dly);
        // R1: armed_q is cleared by reset, so the gate is held off.
        gate     = armed_q && level_ok && time_ok;
    end

endmodule

// File: rtl/dead_band_gen.sv
module dead_band_gen #(
    parameter int unsigned CNT_W = db_pkg::DB_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic [CNT_W-1:0] rise_dly,
    input  logic [CNT_W-1:0] fall_dly,
    output logic             gate_hi,
    output logic             gate_lo
);

    import db_pkg::*;

    logic             level_q;
    logic             armed_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] dly_arr  [DB_NUM_SIDES];
    logic             gate_arr [DB_NUM_SIDES];

    assign dly_arr[DB_SIDE_HI] = rise_dly;
    assign dly_arr[DB_SIDE_LO] = fall_dly;

    db_level_track #(
        .CNT_W (CNT_W)
    ) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (pwm_in),
        .level_q  (level_q),
        .armed_q  (armed_q),
        .run_q    (run_q)
    );

    // R7: both sides share one level, and their active levels are opposite.
    for (genvar g = 0; g < DB_NUM_SIDES; g++) begin : g_side
        db_gate_qual #(
            .CNT_W        (CNT_W),
            .ACTIVE_LEVEL (db_active_level(g))
        ) qual_i (
            .level_q (level_q),
            .armed_q (armed_q),
            .run_q   (run_q),
            .dly     (dly_arr[g]),
            .gate    (gate_arr[g])
        );
    end

    assign gate_hi = gate_arr[DB_SIDE_HI];
    assign gate_lo = gate_arr[DB_SIDE_LO];

endmodule

// File: rtl/dead_band_gen_chk.sv
module dead_band_gen_chk #(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_in,
    input logic [CNT_W-1:0] rise_dly,
    input logic [CNT_W-1:0] fall_dly,
    input logic             gate_hi,
    input logic             gate_lo
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!gate_hi && !gate_lo));

    // R3
    hi_off_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwm_in) |-> !gate_hi);

    // R5
    lo_off_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwm_in) |-> !gate_lo);

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    // R8
    hi_zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_dly == '0) && $past(pwm_in) && $past(rst_n) |-> gate_hi);

    // R8
    lo_zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_dly == '0) && !$past(pwm_in) && $past(rst_n) |-> gate_lo);

endmodule

bind dead_band_gen dead_band_gen_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_in   (pwm_in),
    .rise_dly (rise_dly),
    .fall_dly (fall_dly),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo)
);

// File: tb/dead_band_gen_tb_top.sv
module dead_band_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int HW         = 2048;
    localparam int ROWS       = 10;
    // columns: rise, fall, high run, low run, repeats, requirement number
    localparam int VEC [ROWS][6] = '{
        '{3,   3,   10,  10,  3, 2},   // R2 plain delays
        '{5,   2,   4,   8,   3, 6},   // R6 high run shorter than rise
        '{2,   6,   8,   5,   3, 6},   // R6 low run shorter than fall
        '{0,   0,   3,   3,   3, 8},   // R8 both delays zero
        '{0,   4,   1,   7,   3, 8},   // R8 one-cycle high with zero rise
        '{7,   1,   7,   1,   3, 6},   // R6 runs exactly equal to delays
        '{1,   1,   2,   2,   4, 3},   // R3 short alternation
        '{4,   9,   20,  15,  2, 4},   // R4 long fall delay
        '{12,  3,   13,  30,  2, 5},   // R5 high run one past rise
        '{100, 100, 150, 150, 2, 2}    // R2 typical 1 us setting
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwm_in = 1'b0;
    logic [CNT_W-1:0] rise_dly = '0;
    logic [CNT_W-1:0] fall_dly = '0;
    logic             gate_hi;
    logic             gate_lo;

    int n_cmp = 0;
    int n_bad = 0;
    int edges = 0;
    bit done = 1'b0;
    bit hist [HW];

    always #(CLK_PERIOD/2) clk = ~clk;

    dead_band_gen #(.CNT_W(CNT_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_in   (pwm_in),
        .rise_dly (rise_dly),
        .fall_dly (fall_dly),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Gate expected on when the last dly+1 samples since reset all hold its level.
    function automatic logic expect_gate(input bit want, input int dly);
        if (edges < dly + 1) return 1'b0;
        for (int k = 0; k <= dly; k++) begin
            if (hist[(edges - 1 - k) % HW] != want) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Drive one sample at a falling edge, let it be taken, compare at the next falling edge.
    task automatic tick(input logic v, input string tag);
        pwm_in = v;
        @(posedge clk);
        hist[edges % HW] = v;
        edges++;
        @(negedge clk);
        check(tag, "gate_hi", gate_hi, expect_gate(1'b1, int'(rise_dly)));
        check(tag, "gate_lo", gate_lo, expect_gate(1'b0, int'(fall_dly)));
        check("R7", "overlap", gate_hi && gate_lo, 1'b0);
    endtask

    task automatic do_reset(input logic v);
        @(negedge clk);
        rst_n  = 1'b0;
        pwm_in = v;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1", "gate_hi in reset", gate_hi, 1'b0);
            check("R1", "gate_lo in reset", gate_lo, 1'b0);
        end
        edges = 0;
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        // R1 with zero delays and the raw level high, then idle low.
        rise_dly = '0;
        fall_dly = '0;
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) tick(1'b0, "R10");

        // Table walk: each row repeats a low run then a high run.
        for (int r = 0; r < ROWS; r++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[r][5]);
            rise_dly = CNT_W'(VEC[r][0]);
            fall_dly = CNT_W'(VEC[r][1]);
            for (int p = 0; p < VEC[r][4]; p++) begin
                for (int i = 0; i < VEC[r][3]; i++) tick(1'b0, tag);
                for (int i = 0; i < VEC[r][2]; i++) tick(1'b1, tag);
            end
            for (int i = 0; i < VEC[r][3]; i++) tick(1'b0, tag);
        end

        // R10: a level held through reset still waits its full delay afterwards.
        rise_dly = 10'd3;
        fall_dly = 10'd5;
        do_reset(1'b1);
        for (int i = 0; i < 6; i++) tick(1'b1, "R10");
        do_reset(1'b0);
        for (int i = 0; i < 8; i++) tick(1'b0, "R10");

        // R9: maximum delay, then a level held past the counter's range.
        rise_dly = 10'd1023;
        fall_dly = 10'd0;
        for (int i = 0; i < 1100; i++) tick(1'b1, "R9");
        for (int i = 0; i < 5; i++) tick(1'b0, "R9");
        check("R9", "gate_hi after fall", gate_hi, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule